// File: doc/BRIEF.md
# Ordered store buffer with selectable read forwarding

This block sits between one in-order memory-operation issue port and a shared memory port. Writes are parked in a small queue and retired to memory oldest first, so the issuing core does not wait for them. Reads to addresses that no parked write touches go to memory at once, ahead of the parked writes. A mode pin decides what happens when a read hits a parked write. With `relaxed_mode` low the read is held until every write to that word has reached memory. With `relaxed_mode` high the read is answered from the youngest parked write to that word.

Two further operations keep ordering. An atomic compare-and-swap waits until the queue is empty and then goes to memory as one operation. A fence carries no data and is accepted only once the queue is empty, which orders every later read behind every earlier write.

Back-pressure rules: the issue side holds `iss_valid` and every issue field steady until `iss_ready` is seen high at a clock edge. The block holds `mem_req_valid` and every request field steady until `mem_req_ready` is seen high. Only one read or compare-and-swap is in flight at a time. Its answer comes back as a single-cycle `mem_rsp_valid` pulse. Results go to the core as a single-cycle `rsp_valid` pulse that cannot be refused. `relaxed_mode` may change only while no operation is pending.

Top module: `sob_top`

## Requirements
- R1: After reset the queue is empty, `mem_req_valid` is low and `rsp_valid` is low.
- R2: Each accepted store (`iss_op` = 1) causes exactly one memory write (`mem_req_op` = 1) with the same address and data. Writes reach memory in the order the stores were accepted.
- R3: A load (`iss_op` = 0) whose address matches no queued store is sent to memory as a read (`mem_req_op` = 0). It is sent ahead of queued stores. When a fresh drain and such a load compete in the same cycle, the load wins the memory port.
- R4: With `relaxed_mode` low, a load whose word address matches a queued store keeps `iss_ready` low until no queued store matches it.
- R5: With `relaxed_mode` high, a load that matches queued stores is accepted without a memory request. It returns the data of the youngest matching store on `rsp_data`, with `rsp_valid` high in the cycle after acceptance.
- R6: A compare-and-swap (`iss_op` = 2) is accepted only when the queue is empty. It is sent as `mem_req_op` = 2 carrying `iss_wdata` and `iss_cmp`, and its result is the old memory word.
- R7: A fence (`iss_op` = 3) is accepted only when the queue is empty. It produces no memory request and no response.
- R8: A store is refused (`iss_ready` low) while the queue holds DEPTH entries.
- R9: Once `mem_req_valid` is high without `mem_req_ready`, the request and its fields stay unchanged in the next cycle.
- R10: No read or compare-and-swap is sent while an earlier one is still awaiting `mem_rsp_valid`. Its result appears on `rsp_data` with `rsp_valid` one cycle after `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relaxed_mode | input | 1 | 1: forward from queue, 0: stall matching loads |
| iss_valid | input | 1 | Issue operation valid |
| iss_ready | output | 1 | Issue operation accepted this cycle |
| iss_op | input | 2 | 0 load, 1 store, 2 compare-and-swap, 3 fence |
| iss_addr | input | AW | Word address |
| iss_wdata | input | DW | Store data or swap value |
| iss_cmp | input | DW | Compare value for compare-and-swap |
| rsp_valid | output | 1 | Result pulse for load or compare-and-swap |
| rsp_data | output | DW | Result data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_op | output | 2 | 0 read, 1 write, 2 compare-and-swap |
| mem_req_addr | output | AW | Request word address |
| mem_req_wdata | output | DW | Write or swap data |
| mem_req_cmp | output | DW | Compare value |
| mem_rsp_valid | input | 1 | Read or swap result pulse |
| mem_rsp_data | input | DW | Read or swap result |

## Verification
The bench builds the block with DEPTH 4, a 4-bit address and 16-bit data. With only four slots, a handful of stores fills the queue and exposes the full-queue stall. The small address space makes repeated stores to one word common, so the youngest-match choice and the strict-mode hold are hit often, both in directed cases and in a generated mixed stream that is run in both modes. Its memory model throttles ready in a fixed pattern or holds it low. This keeps stores queued while loads, fences and swaps arrive.

// File: rtl/sob_pkg.sv
package sob_pkg;
  typedef enum logic [1:0] {
    ISS_LOAD  = 2'd0,
    ISS_STORE = 2'd1,
    ISS_CAS   = 2'd2,
    ISS_FENCE = 2'd3
  } iss_op_e;

  typedef enum logic [1:0] {
    MEM_READ  = 2'd0,
    MEM_WRITE = 2'd1,
    MEM_CAS   = 2'd2
  } mem_op_e;
endpackage

// File: rtl/sob_fifo.sv
module sob_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [AW-1:0]    push_addr,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [AW-1:0]    ent_addr [DEPTH],
  output logic [DW-1:0]    ent_data [DEPTH],
  output logic [PTR_W-1:0] head,
  output logic [CNT_W-1:0] cnt
);
  logic [PTR_W-1:0] tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_addr[s] <= '0;
        ent_data[s] <= '0;
      end else if (push && tail == PTR_W'(s)) begin
        ent_addr[s] <= push_addr;
        ent_data[s] <= push_data;
      end
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < CNT_W'(DEPTH)))
    else $error("R8: push into full queue");

  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0))
    else $error("R2: drain from empty queue");
endmodule

// File: rtl/sob_match.sv
module sob_match #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [DW-1:0]    ent_data [DEPTH],
  input  logic [PTR_W-1:0] head,
  input  logic [CNT_W-1:0] cnt,
  input  logic [AW-1:0]    q_addr,
  output logic             hit,
  output logic [DW-1:0]    hit_data
);
  // Walk from oldest to youngest; a later match overrides, so the youngest wins.
  always_comb begin
    logic [PTR_W-1:0] slot;
    hit      = 1'b0;
    hit_data = '0;
    slot     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + PTR_W'(k);
      if ((CNT_W'(k) < cnt) && (ent_addr[slot] == q_addr)) begin
        hit      = 1'b1;
        hit_data = ent_data[slot];
      end
    end
  end
endmodule

// File: rtl/sob_resp.sv
module sob_resp #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_fire,
  input  logic [DW-1:0] fwd_data,
  input  logic          rd_issue,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          rd_busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic mem_done;
  assign mem_done = rd_busy && mem_rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rd_issue)      rd_busy <= 1'b1;
      else if (mem_done) rd_busy <= 1'b0;
      rsp_valid <= fwd_fire || mem_done;
      if (fwd_fire)      rsp_data <= fwd_data;
      else if (mem_done) rsp_data <= mem_rsp_data;
    end
  end

  a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !rd_busy)
    else $error("R10: second read while one outstanding");

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy && mem_rsp_valid) |=> rsp_valid)
    else $error("R10: memory result not returned");
endmodule

// File: rtl/sob_top.sv
module sob_top #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          relaxed_mode,
  input  logic          iss_valid,
  output logic          iss_ready,
  input  logic [1:0]    iss_op,
  input  logic [AW-1:0] iss_addr,
  input  logic [DW-1:0] iss_wdata,
  input  logic [DW-1:0] iss_cmp,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [1:0]    mem_req_op,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  output logic [DW-1:0] mem_req_cmp,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  import sob_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [PTR_W-1:0] head;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic [DW-1:0]    hit_data;
  logic             rd_busy;
  logic             drain_lock;
  logic             q_empty, q_full;
  logic             is_load, is_store, is_cas, is_fence;
  logic             fwd_ok, bypass_req, drain_req;
  logic             push, pop, fwd_fire, rd_issue;

  assign q_empty = (cnt == '0);
  assign q_full  = (cnt == CNT_W'(DEPTH));

  assign is_load  = iss_valid && (iss_op == ISS_LOAD);
  assign is_store = iss_valid && (iss_op == ISS_STORE);
  assign is_cas   = iss_valid && (iss_op == ISS_CAS);
  assign is_fence = iss_valid && (iss_op == ISS_FENCE);

  // Read side: forward, bypass to memory, or wait.
  assign fwd_ok     = is_load && relaxed_mode && hit && !rd_busy;
  assign bypass_req = !drain_lock && !rd_busy &&
                      ((is_load && !hit) || (is_cas && q_empty));
  assign drain_req  = !q_empty && !bypass_req;

  always_comb begin
    unique case (iss_op)
      ISS_LOAD:  iss_ready = fwd_ok || (bypass_req && mem_req_ready);
      ISS_STORE: iss_ready = !q_full;
      ISS_CAS:   iss_ready = bypass_req && mem_req_ready;
      default:   iss_ready = q_empty;
    endcase
  end

  // Memory port: a bypassing read beats a fresh drain.
  always_comb begin
    mem_req_valid = bypass_req || drain_req;
    if (bypass_req) begin
      mem_req_op    = is_cas ? MEM_CAS : MEM_READ;
      mem_req_addr  = iss_addr;
      mem_req_wdata = is_cas ? iss_wdata : '0;
      mem_req_cmp   = is_cas ? iss_cmp : '0;
    end else begin
      mem_req_op    = MEM_WRITE;
      mem_req_addr  = ent_addr[head];
      mem_req_wdata = ent_data[head];
      mem_req_cmp   = '0;
    end
  end

  assign push     = is_store && !q_full;
  assign pop      = drain_req && mem_req_ready;
  assign fwd_fire = fwd_ok;
  assign rd_issue = bypass_req && mem_req_ready;

  // A refused drain keeps the port until it is taken, so the request stays steady.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        drain_lock <= 1'b0;
    else if (drain_req && !mem_req_ready) drain_lock <= 1'b1;
    else                               drain_lock <= 1'b0;
  end

  sob_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (iss_addr),
    .push_data (iss_wdata),
    .pop       (pop),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .head      (head),
    .cnt       (cnt)
  );

  sob_match #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_match (
    .ent_addr (ent_addr),
    .ent_data (ent_data),
    .head     (head),
    .cnt      (cnt),
    .q_addr   (iss_addr),
    .hit      (hit),
    .hit_data (hit_data)
  );

  sob_resp #(.DW(DW)) u_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .fwd_fire      (fwd_fire),
    .fwd_data      (hit_data),
    .rd_issue      (rd_issue),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rd_busy       (rd_busy),
    .rsp_valid     (rsp_valid),
    .rsp_data      (rsp_data)
  );

  a_r4_strict_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && !relaxed_mode && hit) |-> !iss_ready)
    else $error("R4: strict load accepted over matching store");

  a_r6_cas_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_op == MEM_CAS) |-> q_empty)
    else $error("R6: swap issued with stores queued");

  a_r7_fence_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fence && iss_ready) |-> q_empty)
    else $error("R7: fence passed non-empty queue");

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_op) && $stable(mem_req_addr) &&
       $stable(mem_req_wdata) && $stable(mem_req_cmp)))
    else $error("R9: memory request changed while refused");

  a_r5_fwd_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && iss_ready && relaxed_mode && hit) |-> !(mem_req_valid && mem_req_op == MEM_READ))
    else $error("R5: forwarded load also went to memory");
endmodule

// File: tb/test_sob_top.sv
module test_sob_top;
  localparam int DEPTH = 4;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int NW    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          relaxed_mode = 1'b0;
  logic          iss_valid = 1'b0;
  logic          iss_ready;
  logic [1:0]    iss_op = 2'd0;
  logic [AW-1:0] iss_addr = '0;
  logic [DW-1:0] iss_wdata = '0;
  logic [DW-1:0] iss_cmp = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [1:0]    mem_req_op;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic [DW-1:0] mem_req_cmp;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  sob_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_sob_top (
    .clk(clk), .rst_n(rst_n), .relaxed_mode(relaxed_mode),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_addr(iss_addr), .iss_wdata(iss_wdata), .iss_cmp(iss_cmp),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_cmp(mem_req_cmp),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_rd = 0;
  bit mem_stall = 1'b0;
  logic [DW-1:0] mem_arr [NW];
  logic [DW-1:0] ref_arr [NW];
  logic [DW-1:0] exp_rsp [$];
  logic [AW+DW-1:0] exp_wr [$];
  bit rsp_pend = 1'b0;
  logic [DW-1:0] rsp_val = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Memory model: handshakes taken at the edge, answers driven at the falling edge.
  always @(posedge clk) begin
    cyc++;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      case (mem_req_op)
        2'd1: begin
          if (exp_wr.size() == 0) chk(1'b0, "R2 unexpected write", int'(mem_req_addr), 0);
          else begin
            logic [AW+DW-1:0] e;
            e = exp_wr.pop_front();
            chk({mem_req_addr, mem_req_wdata} == e, "R2 write order",
                int'({mem_req_addr, mem_req_wdata}), int'(e));
          end
          mem_arr[mem_req_addr] = mem_req_wdata;
        end
        2'd0: begin
          n_rd++;
          rsp_pend = 1'b1;
          rsp_val  = mem_arr[mem_req_addr];
        end
        default: begin
          rsp_pend = 1'b1;
          rsp_val  = mem_arr[mem_req_addr];
          if (mem_arr[mem_req_addr] == mem_req_cmp) mem_arr[mem_req_addr] = mem_req_wdata;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid <= rsp_pend;
    mem_rsp_data  <= rsp_val;
    rsp_pend = 1'b0;
    mem_req_ready <= mem_stall ? 1'b0 : ((cyc % 3) != 2);
  end

  // Scoreboard monitor for results.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_rsp.size() == 0) chk(1'b0, "R10 unexpected result", int'(rsp_data), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_rsp.pop_front();
        chk(rsp_data == e, "R3/R5/R6 result data", int'(rsp_data), int'(e));
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] c);
    bit r;
    iss_valid = 1'b1; iss_op = op; iss_addr = a; iss_wdata = d; iss_cmp = c;
    forever begin
      #9;
      r = iss_ready;
      if (r) begin
        case (op)
          2'd0: exp_rsp.push_back(ref_arr[a]);
          2'd1: begin ref_arr[a] = d; exp_wr.push_back({a, d}); end
          2'd2: begin
            exp_rsp.push_back(ref_arr[a]);
            if (ref_arr[a] == c) ref_arr[a] = d;
          end
          default: ;
        endcase
      end
      @(negedge clk);
      if (r) break;
    end
    iss_valid = 1'b0;
  endtask

  task automatic hold_check(input string tag);
    repeat (3) begin
      #9;
      chk(!iss_ready, tag, int'(iss_ready), 0);
      @(negedge clk);
    end
    mem_stall = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (n < 3) begin
      @(negedge clk);
      if (!mem_req_valid && exp_rsp.size() == 0 && exp_wr.size() == 0) n++;
      else n = 0;
    end
  endtask

  task automatic mixed(input int count, inout logic [15:0] lf);
    for (int i = 0; i < count; i++) begin
      logic [AW-1:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a  = {1'b0, lf[5:3]};
      case (lf[2:0])
        3'd0, 3'd1, 3'd2: issue(2'd0, a, '0, '0);
        3'd6: issue(2'd2, a, lf ^ 16'h5a5a, lf[8] ? ref_arr[a] : ~ref_arr[a]);
        3'd7: issue(2'd3, a, '0, '0);
        default: issue(2'd1, a, lf, '0);
      endcase
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    int rd0;
    for (int i = 0; i < NW; i++) begin
      mem_arr[i] = DW'(i * 3 + 1);
      ref_arr[i] = DW'(i * 3 + 1);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req_valid == 1'b0, "R1 idle after reset", int'(mem_req_valid), 0);

    // R2/R3/R4: strict-mode stream under throttled ready
    issue(2'd1, 4'd1, 16'h1111, '0);
    issue(2'd1, 4'd2, 16'h2222, '0);
    issue(2'd0, 4'd1, '0, '0);
    issue(2'd0, 4'd5, '0, '0);
    issue(2'd1, 4'd1, 16'h1112, '0);
    issue(2'd0, 4'd1, '0, '0);
    wait_idle();

    // R4: strict load over a held store stalls
    mem_stall = 1'b1;
    issue(2'd1, 4'd3, 16'h3333, '0);
    fork
      issue(2'd0, 4'd3, '0, '0);
      hold_check("R4 strict stall");
    join
    wait_idle();

    // R3: a fresh load to another word wins the port over the drain
    mem_stall = 1'b1;
    issue(2'd1, 4'd4, 16'h4444, '0);
    fork
      issue(2'd0, 4'd6, '0, '0);
      begin
        #9;
        chk(mem_req_valid && mem_req_op == 2'd0 && mem_req_addr == 4'd6,
            "R3 bypass read first", int'({mem_req_op, mem_req_addr}), int'({2'd0, 4'd6}));
        @(negedge clk);
        mem_stall = 1'b0;
      end
    join
    wait_idle();

    // R8: full queue refuses a store
    mem_stall = 1'b1;
    for (int i = 0; i < DEPTH; i++) issue(2'd1, AW'(8 + i), DW'(16'h8000 + i), '0);
    fork
      issue(2'd1, 4'd12, 16'hc0c0, '0);
      hold_check("R8 full stall");
    join
    wait_idle();

    // R6: swap waits for empty queue
    mem_stall = 1'b1;
    issue(2'd1, 4'd7, 16'h7777, '0);
    fork
      issue(2'd2, 4'd7, 16'h7070, 16'h7777);
      hold_check("R6 swap stall");
    join
    issue(2'd2, 4'd7, 16'h0bad, 16'h1234);
    wait_idle();

    // R7: fence waits for empty queue, then a load sees the store
    mem_stall = 1'b1;
    issue(2'd1, 4'd9, 16'h9999, '0);
    fork
      issue(2'd3, 4'd0, '0, '0);
      hold_check("R7 fence stall");
    join
    chk(mem_req_valid == 1'b0, "R7 fence no request", int'(mem_req_valid), 0);
    issue(2'd0, 4'd9, '0, '0);
    wait_idle();

    // R5: relaxed forwarding takes the youngest match, no memory read
    relaxed_mode = 1'b1;
    mem_stall = 1'b1;
    @(negedge clk);
    issue(2'd1, 4'd2, 16'haaaa, '0);
    issue(2'd1, 4'd2, 16'hbbbb, '0);
    issue(2'd1, 4'd11, 16'hcccc, '0);
    rd0 = n_rd;
    issue(2'd0, 4'd2, '0, '0);
    @(negedge clk);
    chk(exp_rsp.size() == 0, "R5 forwarded without memory", exp_rsp.size(), 0);
    chk(n_rd == rd0, "R5 no memory read", n_rd, rd0);
    mem_stall = 1'b0;
    wait_idle();

    // Mixed streams in both modes
    lf = 16'hace1;
    mixed(60, lf);
    wait_idle();
    relaxed_mode = 1'b0;
    @(negedge clk);
    mixed(60, lf);
    wait_idle();

    for (int i = 0; i < NW; i++)
      chk(mem_arr[i] == ref_arr[i], "R2 final memory", int'(mem_arr[i]), int'(ref_arr[i]));
    chk(mem_req_valid == 1'b0, "R2 drained", int'(mem_req_valid), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule